// File: doc/BRIEF.md
# Two-Level Secondary Bus Arbiter

This block decides which master may drive a shared parallel bus that has four external masters and the bridge's own secondary-side initiator. Every requester is placed in either a high or a low priority group by one configuration bit. The high group rotates round-robin, and the low group as a whole takes a single slot in that rotation. Inside the low group a second round-robin picks the member. With n high-priority masters, each low-priority member therefore gets a turn within a bounded number of transactions.

Grants are registered and active low. A grant is only moved when the current holder stops requesting or when a new transaction begins, which is detected as a falling edge on the frame signal. When nobody else requests, the grant stays parked on the last holder. On an idle bus a handoff leaves one cycle with no grant, so two masters never see a grant edge in the same cycle. On a busy bus the grant moves in one cycle, which is hidden arbitration.

Top module: `sba_arbiter`

## Requirements
- R1: After reset and until the first request, every grant is deasserted. At any time at most one grant is asserted.
- R2: Index N_EXT (4 by default) is the bridge's own requester. Indices 0 to N_EXT-1 are the external masters. Bit i of `hi_grp` set to 1 places requester i in the high group, and 0 places it in the low group.
- R3: When no grant is held, a request is granted on the first clock edge that samples it.
- R4: The low group occupies one slot after the high members in the high-level rotation. With high members {0,1} and all five requesting, successive grants run 0,1,2,0,1,3,0,1,4 and then repeat.
- R5: Within each group the search starts just after that group's most recent winner. After reset each search starts at index 0.
- R6: With `hi_grp` all zero, all requesters form one round-robin: 0,1,2,3,4,0,...
- R7: If the grant must move while the bus is idle (`frame_n` and `irdy_n` both high), the next edge removes all grants and the following edge asserts the new one.
- R8: If the grant must move while the bus is busy, it moves directly from the old holder to the new holder on one edge.
- R9: With no requests present, the current grant stays where it is (parking).
- R10: While the holder keeps requesting and no transaction starts, the grant does not move, even if others request. A transaction start is `frame_n` high on the previous sampled edge and low on this one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N_EXT+1 | Active-low requests; the top index is the bridge |
| frame_n | input | 1 | Active-low frame from the bus |
| irdy_n | input | 1 | Active-low initiator ready from the bus |
| hi_grp | input | N_EXT+1 | Group select per requester, 1 = high group |
| gnt_n | output | N_EXT+1 | Active-low registered grants |

## Verification
Every grant is registered, so a decision made on the inputs sampled at one rising edge shows on `gnt_n` right after that edge. The one exception is the idle-bus handoff: it first shows an all-off grant after one edge and the new grant after the second edge. The bench changes inputs on falling edges and samples one nanosecond after the rising edge that is expected to produce the result. For the idle handoff it samples both the empty cycle and the grant cycle. The rotation sweeps start a transaction once per step and compare each grant against sequences computed arithmetically from the group split. Between starts they also check that the grant holds still.

// File: rtl/sba_pkg.sv
package sba_pkg;
   // Width of an index able to address N requesters plus the group slot
   function automatic int slot_width(input int n);
      return (n + 1 <= 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/sba_rr_pick.sv
module sba_rr_pick #(
   parameter int W  = 5,
   parameter int IW = 3
) (
   input  logic [W-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] idx
);
   if (W < 2) begin : g_bad_w
      $error("sba_rr_pick: W must be at least 2");
   end
   if ((1 << IW) < W) begin : g_bad_iw
      $error("sba_rr_pick: IW too narrow for W");
   end

   int c;
   always_comb begin
      any = 1'b0;
      idx = '0;
      c   = 0;
      for (int k = 1; k <= W; k++) begin
         c = (int'(last) + k) % W;
         if (!any && req[c]) begin
            any = 1'b1;
            idx = IW'(c);
         end
      end
   end
endmodule

// File: rtl/sba_grant_ctl.sv
module sba_grant_ctl #(
   parameter int N_REQ = 5,
   parameter int IW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_REQ-1:0] req,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic             win_any,
   input  logic [IW-1:0]    win_idx,
   output logic             commit,
   output logic [N_REQ-1:0] gnt
);
   logic             own_vld, pend_vld, frame_q;
   logic [IW-1:0]    own_idx, pend_idx;
   logic             idle, start, rearb;
   logic [N_REQ-1:0] win_vec, pend_vec;

   always_comb begin
      idle     = frame_n & irdy_n;
      start    = frame_q & ~frame_n;
      rearb    = !own_vld || !req[own_idx] || start;
      commit   = !pend_vld && rearb && win_any && !(own_vld && (win_idx == own_idx));
      win_vec  = '0;
      win_vec[win_idx] = 1'b1;
      pend_vec = '0;
      pend_vec[pend_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_vld  <= 1'b0;
         own_idx  <= '0;
         pend_vld <= 1'b0;
         pend_idx <= '0;
         frame_q  <= 1'b1;
         gnt      <= '0;
      end else begin
         frame_q <= frame_n;
         if (pend_vld) begin
            gnt      <= pend_vec;
            own_vld  <= 1'b1;
            own_idx  <= pend_idx;
            pend_vld <= 1'b0;
         end else if (commit) begin
            if (own_vld && idle) begin
               gnt      <= '0;
               own_vld  <= 1'b0;
               pend_vld <= 1'b1;
               pend_idx <= win_idx;
            end else begin
               gnt     <= win_vec;
               own_vld <= 1'b1;
               own_idx <= win_idx;
            end
         end
      end
   end
endmodule

// File: rtl/sba_arbiter.sv
module sba_arbiter #(
   parameter int N_EXT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT:0]   req_n,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic [N_EXT:0]   hi_grp,
   output logic [N_EXT:0]   gnt_n
);
   localparam int N_REQ   = N_EXT + 1;
   localparam int IW      = sba_pkg::slot_width(N_REQ);
   localparam int LO_SLOT = N_REQ;

   if (N_EXT < 1 || N_EXT > 15) begin : g_bad_n
      $error("sba_arbiter: N_EXT must be 1..15");
   end

   logic [N_REQ-1:0] req, hi_req, lo_req, gnt;
   logic [N_REQ:0]   top_req;

   for (genvar i = 0; i < N_REQ; i++) begin : g_split
      assign req[i]    = ~req_n[i];
      assign hi_req[i] = req[i] & hi_grp[i];
      assign lo_req[i] = req[i] & ~hi_grp[i];
   end

   logic          lo_any, top_any, commit, win_is_lo;
   logic [IW-1:0] lo_idx, top_idx, win_idx, hi_last, lo_last;

   sba_rr_pick #(.W(N_REQ), .IW(IW)) u_lo_pick (
      .req(lo_req), .last(lo_last), .any(lo_any), .idx(lo_idx));

   assign top_req = {lo_any, hi_req};

   sba_rr_pick #(.W(N_REQ + 1), .IW(IW)) u_top_pick (
      .req(top_req), .last(hi_last), .any(top_any), .idx(top_idx));

   assign win_is_lo = (top_idx == IW'(LO_SLOT));
   assign win_idx   = win_is_lo ? lo_idx : top_idx;

   sba_grant_ctl #(.N_REQ(N_REQ), .IW(IW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .req(req), .frame_n(frame_n), .irdy_n(irdy_n),
      .win_any(top_any), .win_idx(win_idx), .commit(commit), .gnt(gnt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_last <= IW'(LO_SLOT);
         lo_last <= IW'(N_REQ - 1);
      end else if (commit) begin
         hi_last <= top_idx;
         if (win_is_lo) lo_last <= lo_idx;
      end
   end

   assign gnt_n = ~gnt;
endmodule

// File: rtl/sba_arbiter_chk.sv
module sba_arbiter_chk #(
   parameter int N_REQ = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_REQ-1:0] req_n,
   input logic             frame_n,
   input logic             irdy_n,
   input logic [N_REQ-1:0] gnt_n
);
   logic frame_d, start, idle;
   always_ff @(posedge clk) begin
      if (!rst_n) frame_d <= 1'b1;
      else        frame_d <= frame_n;
   end
   assign start = frame_d & ~frame_n;
   assign idle  = frame_n & irdy_n;

   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~gnt_n));

   a_r7_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(~gnt_n) != '0) && ((~gnt_n) != '0) && (gnt_n != $past(gnt_n)))
      |-> !$past(idle));

   a_r9_park: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(~gnt_n) != '0) && (&$past(req_n))) |-> (gnt_n == $past(gnt_n)));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(~gnt_n) != '0) && (($past(~gnt_n) & ~$past(req_n)) != '0) && !$past(start))
      |-> (gnt_n == $past(gnt_n)));
endmodule

bind sba_arbiter sba_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
   .irdy_n(irdy_n), .gnt_n(gnt_n));

// File: tb/test_sba_arbiter.sv
module test_sba_arbiter;
   localparam int NE = 4;
   localparam int NR = NE + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] req_n = '1;
   logic          frame_n = 1'b1;
   logic          irdy_n = 1'b1;
   logic [NR-1:0] hi_grp = '0;
   logic [NR-1:0] gnt_n;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sba_arbiter #(.N_EXT(NE)) i_sba_arbiter (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
      .irdy_n(irdy_n), .hi_grp(hi_grp), .gnt_n(gnt_n));

   task automatic chk(input logic [NR-1:0] exp, input string tag);
      n_chk++;
      if ((~gnt_n) !== exp) begin
         n_bad++;
         $display("FAIL %s: grant=%b expected=%b", tag, ~gnt_n, exp);
      end
   endtask

   task automatic setin(input logic [NR-1:0] rq, input logic fr, input logic ir);
      @(negedge clk);
      req_n   = ~rq;
      frame_n = fr;
      irdy_n  = ir;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic [NR-1:0] grp);
      @(negedge clk);
      rst_n = 1'b0; req_n = '1; frame_n = 1'b1; irdy_n = 1'b1; hi_grp = grp;
      repeat (3) @(posedge clk);
      #1;
      chk('0, "R1 reset grants off");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic int seq_two_high(input int k);
      if ((k % 3) < 2) return k % 3;
      return 2 + ((k / 3) % 3);
   endfunction

   initial begin
      // R1/R3/R2: bridge requester alone gets an immediate grant
      do_reset('0);
      step();
      chk('0, "R1 idle no grant");
      setin(5'b10000, 1'b1, 1'b1);
      step();
      chk(5'b10000, "R3 R2 bridge first grant");

      // R9 parking, then R7 idle handoff with gap
      do_reset('0);
      setin(5'b00100, 1'b1, 1'b1);
      step();
      chk(5'b00100, "R3 first grant");
      setin(5'b00000, 1'b1, 1'b1);
      repeat (3) step();
      chk(5'b00100, "R9 parked");
      setin(5'b01000, 1'b1, 1'b1);
      step();
      chk(5'b00000, "R7 gap cycle");
      step();
      chk(5'b01000, "R7 new grant");

      // R8 busy handoff in one edge
      setin(5'b01000, 1'b0, 1'b0);
      step();
      chk(5'b01000, "R8 same holder on start");
      setin(5'b00010, 1'b0, 1'b0);
      step();
      chk(5'b00010, "R8 direct move");

      // R10 no move while holder requests without a start
      setin(5'b00011, 1'b1, 1'b1);
      repeat (3) step();
      chk(5'b00010, "R10 holder keeps grant");
      setin(5'b00011, 1'b0, 1'b1);
      step();
      chk(5'b00001, "R10 R5 move on start");
      setin(5'b00011, 1'b1, 1'b1);

      // R4/R5: high group {0,1}, low group {2,3,4}
      do_reset(5'b00011);
      setin('1, 1'b1, 1'b1);
      step();
      chk(NR'(1) << seq_two_high(0), "R4 k=0");
      for (int k = 1; k < 18; k++) begin
         setin('1, 1'b0, 1'b1);
         step();
         chk(NR'(1) << seq_two_high(k), $sformatf("R4 R5 k=%0d", k));
         setin('1, 1'b1, 1'b1);
         step();
         chk(NR'(1) << seq_two_high(k), $sformatf("R10 steady k=%0d", k));
      end

      // R6: all low gives one round-robin
      do_reset('0);
      setin('1, 1'b1, 1'b1);
      step();
      chk(NR'(1), "R6 k=0");
      for (int k = 1; k < 10; k++) begin
         setin('1, 1'b0, 1'b1);
         step();
         chk(NR'(1) << (k % NR), $sformatf("R6 k=%0d", k));
         setin('1, 1'b1, 1'b1);
         step();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule